// File: doc/BRIEF.md
# 64-bit Nanosecond Alarm Timer

This peripheral keeps a free-running, signed 64-bit count of nanoseconds. On every clock cycle with the `tick` input high, the count grows by a fixed step of `STEP_NS` nanoseconds. Software reaches the block through a plain 32-bit register port with a 4 KB address window.

The count is read as two words. Reading the low word also captures the upper word in a shadow, so the pair always comes from one instant, even when a carry crosses bit 32 between the two reads.

A one-shot alarm is loaded in two writes. The upper half is staged first, and the write of the lower half loads the full 64-bit compare value and arms it. When the count reaches the alarm, the alarm disarms itself and sets a sticky pending flag. That flag drives the interrupt line whenever the enable bit is set, and stays set until software clears it.

Top module: `alarm_timer64`

## Requirements
- R1: The count resets to 0. On every cycle with `tick` high it grows by `STEP_NS` (modulo 2^64); with `tick` low it holds its value.
- R2: A read of offset 0x00 returns count bits [31:0] and, on the same clock edge, copies count bits [63:32] into a shadow word. A read of offset 0x04 returns the shadow word, not the live upper bits.
- R3: A write to offset 0x0C stages the upper alarm word. A write to offset 0x08 loads the 64-bit alarm as {staged word, written data} and arms it. Offset 0x08 reads back the active lower alarm word, and 0x0C reads back the staged word.
- R4: An armed alarm fires at the first clock edge at which the count, compared as a signed value, is greater than or equal to the alarm, also compared as a signed value. An alarm loaded with a value already reached therefore fires at the next edge. Firing disarms the alarm and sets the pending flag, and the alarm stays disarmed until offset 0x08 is written again.
- R5: Offset 0x18 reads 1 in bit 0 while an alarm is armed, and 0 otherwise. A write to offset 0x14 disarms the alarm without firing it.
- R6: Bit 0 of a write to offset 0x10 sets the interrupt enable, and 0x10 reads that bit back. `irq` is high exactly when the pending flag and the enable are both set, so a flag set while masked appears as soon as the enable is written to 1.
- R7: A write to offset 0x1C clears the pending flag. If an alarm fires at the same edge, the flag stays set.
- R8: Any offset other than the eight word offsets 0x00 to 0x1C reads 0 and ignores writes, including offsets whose two low address bits are not zero. Offsets 0x14 and 0x1C always read 0.
- R9: After reset, the count, alarm, staged word, shadow, enable, armed flag and pending flag are all 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Advance the count by STEP_NS this cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect: shadow capture at 0x00) |
| addr | input | AW (12) | Byte offset inside the register window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current `addr`, combinational |
| irq | output | 1 | Level interrupt: pending flag AND enable |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high together on one offset. They also assume that a clear-alarm write never coincides with an arming write. Both assumptions matter only for the properties about disarming and the shadow. The stimulus issues at most one register access per cycle, so these collisions cannot arise. It still lines a clear-interrupt write up with a firing edge, to exercise the priority in R7. A large count step in the bench carries the count across bit 32 every few ticks, which makes the snapshot behaviour of R2 observable within a short run.

// File: rtl/alarm_timer64.sv
module alarm_timer64 #(
  parameter int          AW      = 12,
  parameter logic [63:0] STEP_NS = 64'd1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          irq
);

  localparam logic [2:0] W_CNT_LO = 3'd0, W_CNT_HI = 3'd1, W_ALM_LO = 3'd2,
                         W_ALM_HI = 3'd3, W_IRQ_EN = 3'd4, W_DISARM = 3'd5,
                         W_STATUS = 3'd6, W_ACK    = 3'd7;

  logic [63:0] cnt, alarm;
  logic [31:0] stage_hi, shadow;
  logic        en, armed, pend;

  logic       hit;
  logic [2:0] wsel;
  assign hit  = (addr[AW-1:5] == '0) && (addr[1:0] == 2'b00);
  assign wsel = addr[4:2];

  logic wr_alo, wr_ahi, wr_en_reg, wr_disarm, wr_ack, rd_clo;
  assign wr_alo    = wr_en && hit && (wsel == W_ALM_LO);
  assign wr_ahi    = wr_en && hit && (wsel == W_ALM_HI);
  assign wr_en_reg = wr_en && hit && (wsel == W_IRQ_EN);
  assign wr_disarm = wr_en && hit && (wsel == W_DISARM);
  assign wr_ack    = wr_en && hit && (wsel == W_ACK);
  assign rd_clo    = rd_en && hit && (wsel == W_CNT_LO);

  logic fire;
  assign fire = armed && ($signed(cnt) >= $signed(alarm));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      alarm    <= '0;
      stage_hi <= '0;
      shadow   <= '0;
      en       <= 1'b0;
      armed    <= 1'b0;
      pend     <= 1'b0;
    end else begin
      if (tick)      cnt      <= cnt + STEP_NS;
      if (rd_clo)    shadow   <= cnt[63:32];
      if (wr_ahi)    stage_hi <= wdata;
      if (wr_alo)    alarm    <= {stage_hi, wdata};
      if (wr_en_reg) en       <= wdata[0];

      if (wr_alo)                armed <= 1'b1;
      else if (wr_disarm || fire) armed <= 1'b0;

      if (fire)        pend <= 1'b1;
      else if (wr_ack) pend <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      case (wsel)
        W_CNT_LO: rdata = cnt[31:0];
        W_CNT_HI: rdata = shadow;
        W_ALM_LO: rdata = alarm[31:0];
        W_ALM_HI: rdata = stage_hi;
        W_IRQ_EN: rdata = {31'b0, en};
        W_STATUS: rdata = {31'b0, armed};
        default:  rdata = '0;
      endcase
    end
  end

  assign irq = pend & en;

endmodule

module alarm_timer64_chk #(
  parameter int          AW      = 12,
  parameter logic [63:0] STEP_NS = 64'd1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [31:0]   rdata,
  input logic [63:0]   cnt,
  input logic [31:0]   shadow,
  input logic          armed,
  input logic          pend
);

  logic a_lo, a_dis, a_ack, a_clo, unused_off;
  assign a_lo       = wr_en && (addr == AW'(12'h008));
  assign a_dis      = wr_en && (addr == AW'(12'h014));
  assign a_ack      = wr_en && (addr == AW'(12'h01C));
  assign a_clo      = rd_en && (addr == AW'(12'h000));
  assign unused_off = (addr[AW-1:5] != '0) || (addr[1:0] != 2'b00);

  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(cnt) + STEP_NS);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> cnt == $past(cnt));
  a_r2_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    a_clo |=> shadow == $past(cnt[63:32]));
  a_r3_arm: assert property (@(posedge clk) disable iff (!rst_n)
    a_lo |=> armed);
  a_r5_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    a_dis |=> !armed);
  a_r4_fire_pends: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(armed) && !$past(a_dis)) |-> pend);
  a_r7_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ack && !armed) |=> !pend);
  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unused_off |-> rdata == 32'h0);

endmodule

bind alarm_timer64 alarm_timer64_chk #(.AW(AW), .STEP_NS(STEP_NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .rdata(rdata), .cnt(cnt), .shadow(shadow),
  .armed(armed), .pend(pend)
);

// File: tb/sim_alarm_timer64.sv
module sim_alarm_timer64;
  localparam int          CLK_P = 10;
  localparam logic [63:0] STEP  = 64'h0000_0000_6000_0001;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  alarm_timer64 #(.AW(12), .STEP_NS(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  // behavioural reference state
  logic [63:0] m_cnt = '0, m_alarm = '0;
  logic [31:0] m_stage = '0, m_shadow = '0;
  bit m_en = 0, m_armed = 0, m_pend = 0;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [11:0] a);
    if (a[11:5] != 0 || a[1:0] != 0) return 32'h0;
    case (a[4:2])
      3'd0: return m_cnt[31:0];
      3'd1: return m_shadow;
      3'd2: return m_alarm[31:0];
      3'd3: return m_stage;
      3'd4: return {31'b0, m_en};
      3'd6: return {31'b0, m_armed};
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_step(input bit w, input bit r, input logic [11:0] a,
                        input logic [31:0] d, input bit t);
    bit fire, hit;
    logic [63:0] old_cnt;
    fire = m_armed && ($signed(m_cnt) >= $signed(m_alarm));
    hit = (a[11:5] == 0) && (a[1:0] == 0);
    old_cnt = m_cnt;
    if (t) m_cnt = m_cnt + STEP;
    if (r && hit && a[4:2] == 3'd0) m_shadow = old_cnt[63:32];
    if (fire) begin m_armed = 0; m_pend = 1; end
    if (w && hit) begin
      case (a[4:2])
        3'd2: begin m_alarm = {m_stage, d}; m_armed = 1; end
        3'd3: m_stage = d;
        3'd4: m_en = d[0];
        3'd5: m_armed = 0;
        3'd7: if (!fire) m_pend = 0;
        default: ;
      endcase
    end
  endtask

  task automatic cyc(input bit w, input bit r, input logic [11:0] a,
                     input logic [31:0] d, input bit t, input string tag);
    wr_en = w; rd_en = r; addr = a; wdata = d; tick = t;
    #(CLK_P/4);
    if (r) check(rdata, m_read(a), tag);
    check({31'b0, irq}, {31'b0, m_pend & m_en}, "R6 irq");
    @(posedge clk);
    m_step(w, r, a, d, t);
    @(negedge clk);
    wr_en = 0; rd_en = 0; tick = 0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag); cyc(0, 1, a, 0, 0, tag); endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag); cyc(1, 0, a, d, 0, tag); endtask
  task automatic tk(input int n); for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1, "R1"); endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset state
    for (int i = 0; i < 8; i++) rd(12'(i * 4), "R9 reset");
    check({31'b0, irq}, 32'h0, "R9 irq");
    // R1 / R2: counting and tear-free read
    tk(5);
    rd(12'h000, "R1 count low");
    rd(12'h004, "R2 shadow");
    tk(3);
    rd(12'h004, "R2 shadow held");
    rd(12'h000, "R2 low");
    rd(12'h004, "R2 new shadow");
    // R3 / R5: arm far future then disarm
    wr(12'h00C, 32'h7FFF_FFFF, "R3");
    wr(12'h008, 32'h5, "R3");
    rd(12'h008, "R3 alarm low");
    rd(12'h00C, "R3 alarm high");
    rd(12'h018, "R5 armed");
    tk(4);
    wr(12'h014, 32'h1, "R5");
    rd(12'h018, "R5 disarmed");
    tk(2);
    // R4 / R6: past alarm fires next cycle
    wr(12'h010, 32'h1, "R6");
    rd(12'h010, "R6 enable");
    wr(12'h00C, 32'h0, "R3");
    wr(12'h008, 32'h0, "R4");
    rd(12'h018, "R4 one-shot");
    tk(2);
    rd(12'h018, "R4 stays off");
    // R7: clear
    wr(12'h01C, 32'h1, "R7");
    tk(1);
    // R6: masked pending shows on enable
    wr(12'h010, 32'h0, "R6");
    v = m_cnt + 3 * STEP;
    wr(12'h00C, v[63:32], "R3");
    wr(12'h008, v[31:0], "R4");
    tk(6);
    rd(12'h018, "R4 fired");
    wr(12'h010, 32'h1, "R6");
    tk(1);
    wr(12'h01C, 32'h0, "R7");
    // R4 signed: negative alarm fires at once
    wr(12'h00C, 32'h8000_0000, "R4");
    wr(12'h008, 32'h0, "R4 signed");
    tk(1);
    rd(12'h018, "R4 signed fired");
    // R7: clear collides with fire
    wr(12'h01C, 32'h0, "R7");
    wr(12'h008, 32'h0, "R4");
    wr(12'h01C, 32'h0, "R7 fire wins");
    tk(1);
    // R8: unused offsets
    wr(12'h020, 32'hFFFF_FFFF, "R8");
    wr(12'hFFC, 32'hFFFF_FFFF, "R8");
    wr(12'h00A, 32'hFFFF_FFFF, "R8");
    wr(12'h011, 32'h0, "R8");
    rd(12'h020, "R8 unused");
    rd(12'hFFC, "R8 unused");
    rd(12'h001, "R8 misaligned");
    rd(12'h014, "R8 clear reg");
    rd(12'h01C, "R8 clear reg");
    for (int i = 0; i < 8; i++) rd(12'(i * 4), "R8 regs intact");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int unsigned k;
      logic [11:0] a;
      k = $urandom_range(0, 9);
      a = 12'($urandom_range(0, 8) * 4);
      case (k)
        0, 1, 2: tk(1);
        3, 4:    rd(a, "R1 mix");
        5:       wr(12'h008, 32'($urandom), "R3 mix");
        6:       wr(12'h00C, m_cnt[63:32] + 32'($urandom_range(0, 2)), "R3 mix");
        7:       wr(12'h01C, 0, "R7 mix");
        8:       wr(12'h010, 32'($urandom_range(0, 1)), "R6 mix");
        default: wr(12'h014, 0, "R5 mix");
      endcase
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule